// File: doc/BRIEF.md
# Clock-Activity Power State Controller

This block picks the operating state of a voice codec. The inputs are a hard power-down pin, the serial bit clock and the frame strobe. The block runs on a free-running reference clock. It watches each external clock for edges. A signal that shows no edge for a set number of reference cycles is treated as static, at whichever level it stopped.

The block has three states: operating, power-saving and power-down.
- A low power-down pin always wins. It also requests a synchronous clear of the configuration register.
- A static bit clock or a static frame strobe moves the block from operating to power-saving.
- To return to operating, both signals must toggle again and one complete frame must then pass.

The outputs are the state code, the transmit and receive path enables, and a high-impedance request for the serial PCM output.

Top module: `cap_ctrl`

## Requirements
- R1: After reset the state code is power-down (2'b10). In that state the transmit and receive enables are low, and the high-impedance request and the configuration clear are both high.
- R2: Within 4 reference cycles of the power-down pin going low, from any state, the state code becomes 2'b10 and the configuration clear is asserted.
- R3: Power-down has priority. While the pin is low the state stays 2'b10, whether or not the bit clock and the frame strobe toggle.
- R4: In the operating state (2'b00), a bit clock that holds either level for more than TIMEOUT_CYC reference cycles moves the state to power-saving (2'b01).
- R5: In the operating state, a frame strobe that holds either level for more than TIMEOUT_CYC reference cycles moves the state to power-saving.
- R6: Edge gaps shorter than TIMEOUT_CYC cycles never cause power-saving. A signal that has just toggled counts as active.
- R7: From power-saving, the state becomes operating only after both signals are active and two rising strobe edges have been seen while both stay active, which is one full frame. A single restarted signal keeps the state at 2'b01.
- R8: In power-saving and power-down, the enables are low and the high-impedance request is high. In operating, the enables are high and the request is low.
- R9: The configuration clear is low in power-saving and in operating. Leaving power-saving does not clear the configuration.
- R10: When the pin is released, the state goes from power-down to power-saving, never straight to operating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin_n | input | 1 | Hard power-down request, active low, asynchronous |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| fsync_in | input | 1 | Frame strobe, asynchronous to clk |
| pwr_state | output | 2 | 00 operating, 01 power-saving, 10 power-down |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| pcm_hiz | output | 1 | High-impedance request for the serial output |
| cfg_clr | output | 1 | Synchronous clear for the configuration register |

## Verification
The bench builds the block with TIMEOUT_CYC = 40 in place of the default frame-length value. The stimulus is a bit clock with a 4-cycle period and a frame strobe with a 24-cycle period, so a normal edge gap always stays below the timeout. This keeps both timeout expiry and the one-frame resume wait within a few hundred cycles. It also allows stops at both static levels to be tested, as well as a half-timeout gap that must be tolerated.

// File: rtl/cap_ctrl_pkg.sv
package cap_ctrl_pkg;
  typedef enum logic [1:0] {
    PS_OPER = 2'b00,
    PS_SAVE = 2'b01,
    PS_DOWN = 2'b10
  } pstate_t;

  localparam int SRC_BCLK = 0;
  localparam int SRC_FS   = 1;
  localparam int NSRC     = 2;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d_async;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/cap_act_mon.sv
module cap_act_mon #(
  parameter int TIMEOUT_CYC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic active,
  output logic rise
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic          sig_q;
  logic          edge_seen;
  logic [CW-1:0] gap_cnt, gap_nxt;
  logic          cnt_en;

  assign edge_seen = sig ^ sig_q;
  assign cnt_en    = edge_seen || (gap_cnt != LIMIT);

  always_comb begin
    gap_nxt = gap_cnt;
    if (edge_seen)            gap_nxt = '0;
    else if (gap_cnt != LIMIT) gap_nxt = gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= 1'b0;
      gap_cnt <= LIMIT;
    end else begin
      sig_q <= sig;
      if (cnt_en) gap_cnt <= gap_nxt;
    end
  end

  assign active = (gap_cnt < LIMIT);
  assign rise   = edge_seen & sig;

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= LIMIT);
  assert_edge_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> active);
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_n,
  input  logic [NSRC-1:0] act,
  input  logic [NSRC-1:0] rise,
  output pstate_t         state
);
  pstate_t state_nxt;
  logic    armed, armed_nxt;
  logic    both_act;

  assign both_act = &act;

  always_comb begin
    state_nxt = state;
    armed_nxt = armed;
    if (!pd_n) begin
      state_nxt = PS_DOWN;
      armed_nxt = 1'b0;
    end else begin
      unique case (state)
        PS_DOWN: begin
          state_nxt = PS_SAVE;
          armed_nxt = 1'b0;
        end
        PS_OPER: begin
          if (!both_act) state_nxt = PS_SAVE;
          armed_nxt = 1'b0;
        end
        PS_SAVE: begin
          if (!both_act) begin
            armed_nxt = 1'b0;
          end else if (rise[SRC_FS]) begin
            if (armed) begin
              state_nxt = PS_OPER;
              armed_nxt = 1'b0;
            end else begin
              armed_nxt = 1'b1;
            end
          end
        end
        default: begin
          state_nxt = PS_DOWN;
          armed_nxt = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_DOWN;
      armed <= 1'b0;
    end else begin
      state <= state_nxt;
      armed <= armed_nxt;
    end
  end

  assert_pd_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> state == PS_DOWN);
  assert_down_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_DOWN |=> state != PS_OPER);
  assert_bclk_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OPER && pd_n && !act[SRC_BCLK]) |=> state == PS_SAVE);
  assert_fs_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OPER && pd_n && !act[SRC_FS]) |=> state == PS_SAVE);
  assert_no_early_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SAVE && !both_act) |=> state != PS_OPER);
  assert_bclk_rise_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise[SRC_BCLK] |=> act[SRC_BCLK]);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_ctrl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_pin_n,
  input  logic       bclk_in,
  input  logic       fsync_in,
  output logic [1:0] pwr_state,
  output logic       tx_en,
  output logic       rx_en,
  output logic       pcm_hiz,
  output logic       cfg_clr
);
  logic [NSRC:0]   raw_in, synced;
  logic [NSRC-1:0] act, rise;
  pstate_t         state;

  assign raw_in = {pd_pin_n, fsync_in, bclk_in};

  cap_sync #(.WIDTH(NSRC + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (synced)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_mon
    cap_act_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig    (synced[g]),
      .active (act[g]),
      .rise   (rise[g])
    );
  end

  cap_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .pd_n  (synced[NSRC]),
    .act   (act),
    .rise  (rise),
    .state (state)
  );

  assign pwr_state = state;
  assign tx_en     = (state == PS_OPER);
  assign rx_en     = (state == PS_OPER);
  assign pcm_hiz   = (state != PS_OPER);
  assign cfg_clr   = (state == PS_DOWN);

  assert_hiz_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_hiz |-> !tx_en && !rx_en);
  assert_clr_only_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |-> pcm_hiz);
endmodule

// File: tb/cap_ctrl_tb_top.sv
module cap_ctrl_tb_top;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_pin_n = 1'b0;
  logic bclk_in = 1'b0, fsync_in = 1'b0;
  logic bclk_run = 1'b0, fs_run = 1'b0;
  logic bclk_hold = 1'b0, fs_hold = 1'b0;
  logic [1:0] pwr_state;
  logic tx_en, rx_en, pcm_hiz, cfg_clr;
  int n_chk = 0, n_fail = 0;
  int bc = 0, fc = 0;

  always #10 clk = ~clk;

  cap_ctrl #(.TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_pin_n(pd_pin_n),
    .bclk_in(bclk_in), .fsync_in(fsync_in),
    .pwr_state(pwr_state), .tx_en(tx_en), .rx_en(rx_en),
    .pcm_hiz(pcm_hiz), .cfg_clr(cfg_clr)
  );

  always @(negedge clk) begin
    if (bclk_run) begin
      bc <= (bc == 3) ? 0 : bc + 1;
      bclk_in <= (bc < 2);
    end else begin
      bclk_in <= bclk_hold;
    end
    if (fs_run) begin
      fc <= (fc == 23) ? 0 : fc + 1;
      fsync_in <= (fc < 4);
    end else begin
      fsync_in <= fs_hold;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_state(input string req, input int exp);
    check(pwr_state == 2'(exp), req, int'(pwr_state), exp);
  endtask

  task automatic t_reset();
    wcyc(3);
    rst_n = 1'b1;
    wcyc(2);
    chk_state("R1 state", 2);
    check(!tx_en && !rx_en, "R1 enables", int'({tx_en, rx_en}), 0);
    check(pcm_hiz && cfg_clr, "R1 hiz/clr", int'({pcm_hiz, cfg_clr}), 3);
    bclk_run = 1'b1; fs_run = 1'b1;
    wcyc(100);
    chk_state("R3 clocks running, pin low", 2);
  endtask

  task automatic t_release();
    pd_pin_n = 1'b1;
    wcyc(5);
    chk_state("R10 release to save", 1);
    check(!cfg_clr, "R9 clr in save", int'(cfg_clr), 0);
    wcyc(120);
    chk_state("R7 resume after frame", 0);
    check(tx_en && rx_en && !pcm_hiz, "R8 oper outputs",
          int'({tx_en, rx_en, pcm_hiz}), 6);
    check(!cfg_clr, "R9 clr in oper", int'(cfg_clr), 0);
  endtask

  task automatic t_bclk_stop(input logic lvl, input string req);
    bclk_hold = lvl;
    bclk_run = 1'b0;
    wcyc(TO / 2);
    chk_state("R6 short gap stays oper", 0);
    wcyc(TO + 20);
    chk_state(req, 1);
    check(pcm_hiz && !tx_en && !rx_en, "R8 save outputs",
          int'({tx_en, rx_en, pcm_hiz}), 1);
    bclk_run = 1'b1;
    wcyc(6);
    chk_state("R7 no instant resume", 1);
    wcyc(120);
    chk_state("R7 resume", 0);
  endtask

  task automatic t_fs_stop();
    fs_hold = 1'b1;
    fs_run = 1'b0;
    wcyc(TO + 20);
    chk_state("R5 strobe static high", 1);
    bclk_hold = 1'b0;
    bclk_run = 1'b0;
    wcyc(TO + 20);
    bclk_run = 1'b1;
    wcyc(200);
    chk_state("R7 only bclk restarted", 1);
    fs_run = 1'b1;
    wcyc(6);
    chk_state("R7 wait full frame", 1);
    wcyc(120);
    chk_state("R7 both restarted", 0);
    check(!cfg_clr, "R9 no clear on resume", int'(cfg_clr), 0);
  endtask

  task automatic t_powerdown();
    pd_pin_n = 1'b0;
    wcyc(4);
    chk_state("R2 pin low", 2);
    check(cfg_clr && pcm_hiz, "R2 clr/hiz", int'({cfg_clr, pcm_hiz}), 3);
    bclk_run = 1'b0; fs_run = 1'b0;
    wcyc(TO + 30);
    chk_state("R3 stays down, clocks stopped", 2);
    bclk_run = 1'b1; fs_run = 1'b1;
    wcyc(100);
    chk_state("R3 stays down, clocks resumed", 2);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_release();
    t_bclk_stop(1'b1, "R4 bclk static high");
    t_bclk_stop(1'b0, "R4 bclk static low");
    t_fs_stop();
    t_powerdown();
    t_release();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule